// File: doc/BRIEF.md
# Masked double-to-single float converter

This execution unit takes a 64-bit IEEE-754 double-precision value and produces its 32-bit single-precision equivalent. The result goes into the low 32-bit lane of a 128-bit destination vector. The upper 96 bits of the destination are taken unchanged from a separate first source vector. The unit registers its result, so a request presented with `valid_i` in one cycle yields `valid_o`, the destination vector and the five IEEE exception flags on the next rising edge.

The rounding direction normally comes from a global control field. A per-operation rounding field can override it, but only when the operand is a register and the override enable is set. An optional one-bit write mask decides what the low lane receives: the converted value, the previous low-lane contents (merge), or zero (zeroing). Instruction decode, memory operands and trap delivery are handled by the surrounding pipeline.

Top module: `dp2sp_cvt_unit`

## Requirements
- R1: Registered timing. `valid_o` is 1 exactly one cycle after a cycle with `valid_i`=1 and 0 otherwise. `dest_o` and the flags change only in the cycle after `valid_i`=1 and otherwise hold their values.
- R2: `dest_o[127:32]` equals the `src1_i[127:32]` presented with the request.
- R3: Rounding-mode choice. When `src_reg_i`=1 and `er_en_i`=1, `insn_rm_i` sets the rounding mode; in every other case `ctl_rm_i` sets it.
- R4: Rounding encoding: 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero. An inexact result is rounded in the selected direction and sets the precision flag.
- R5: Overflow. When the rounded magnitude exceeds the largest single, the overflow and precision flags are set. The result is infinity, or the largest finite magnitude (0x7F7FFFFF with the sign) when rounding is toward zero or away from the sign's infinity.
- R6: A result with magnitude below 2^-126 is denormalized before it is rounded. The underflow flag is set when that result is also inexact. A tiny exact result sets no flag.
- R7: NaN input yields a quiet NaN: sign kept, exponent all ones, fraction bit 22 set, fraction bits 21:0 taken from double fraction bits 50:29. The invalid flag is set only for a signalling NaN (double fraction bit 51 = 0).
- R8: Infinities and zeros convert exactly, keep their sign and raise no flag.
- R9: A double denormal input (exponent 0, nonzero fraction) sets the denormal flag.
- R10: Write mask. With `mask_en_i`=0 or `mask_bit_i`=1 the low lane gets the converted value. With `mask_en_i`=1 and `mask_bit_i`=0 it gets `old_lo_i` when `zero_mode_i`=0, or zero when `zero_mode_i`=1.
- R11: A masked-off low lane raises no exception flag.
- R12: Under reset, `valid_o`, `dest_o` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Request strobe |
| src1_i | input | 128 | Source of destination bits 127:32 |
| src2_i | input | 64 | Double-precision operand |
| old_lo_i | input | 32 | Previous low-lane value for merge masking |
| ctl_rm_i | input | 2 | Global rounding mode |
| insn_rm_i | input | 2 | Per-operation rounding mode |
| er_en_i | input | 1 | Per-operation rounding enable |
| src_reg_i | input | 1 | Operand comes from a register |
| mask_en_i | input | 1 | Write masking active |
| mask_bit_i | input | 1 | Mask bit for the low lane |
| zero_mode_i | input | 1 | 1 zeroing, 0 merging |
| valid_o | output | 1 | Result valid |
| dest_o | output | 128 | Destination vector |
| flag_inv_o | output | 1 | Invalid operation |
| flag_den_o | output | 1 | Denormal operand |
| flag_ovf_o | output | 1 | Overflow |
| flag_unf_o | output | 1 | Underflow |
| flag_pre_o | output | 1 | Precision (inexact) |

## Verification
Every result is due exactly one clock edge after its request. The bench drives each request at a falling edge and pushes the expected vector and flags into a queue. A monitor looks at the next falling edge and pops one entry whenever `valid_o` is high, so each result is compared in the one cycle it belongs to. The hold behaviour is checked by changing the inputs with `valid_i` low for several cycles and confirming that the outputs stay unchanged.

// File: rtl/cvt_pkg.sv
package cvt_pkg;

    localparam int DW    = 64;
    localparam int DE    = 11;
    localparam int DF    = 52;
    localparam int SW    = 32;
    localparam int SE    = 8;
    localparam int SF    = 23;
    localparam int DBIAS = 1023;
    localparam int SBIAS = 127;

    typedef enum logic [1:0] {
        RM_RNE = 2'b00,
        RM_RDN = 2'b01,
        RM_RUP = 2'b10,
        RM_RTZ = 2'b11
    } rmode_e;

    typedef struct packed {
        logic inv;
        logic den;
        logic ovf;
        logic unf;
        logic pre;
    } fpflags_t;

endpackage

// File: rtl/cvt_rm_pick.sv
module cvt_rm_pick
    import cvt_pkg::*;
(
    input  rmode_e ctl_rm_i,
    input  rmode_e insn_rm_i,
    input  logic   src_reg_i,
    input  logic   er_en_i,
    output rmode_e rm_o
);
    // per-operation override only for register operands with enable set
    always_comb begin
        if (src_reg_i && er_en_i) rm_o = insn_rm_i;
        else                      rm_o = ctl_rm_i;
    end
endmodule

// File: rtl/cvt_d2s_core.sv
module cvt_d2s_core
    import cvt_pkg::*;
(
    input  logic [DW-1:0] dbl_i,
    input  rmode_e        rm_i,
    output logic [SW-1:0] sgl_o,
    output fpflags_t      flg_o
);
    localparam int MW     = DF + 1;          // mantissa with hidden bit
    localparam int KEEP   = SF + 1;          // kept significand bits
    localparam int PADW   = 32;              // room for right shift
    localparam int WIDE   = MW + PADW;
    localparam int SHW    = 5;
    localparam int EW     = 14;              // signed exponent work width
    localparam int EMAXB  = (1 << SE) - 2;   // largest finite biased exp
    localparam int REBIAS = DBIAS - SBIAS;
    localparam int NANPW  = SF - 1;          // carried payload bits

    logic               sgn;
    logic [DE-1:0]      ex;
    logic [DF-1:0]      fr;
    logic [DE-1:0]      ex_eff;
    logic [MW-1:0]      mant;
    logic signed [EW-1:0] es;
    logic signed [EW-1:0] sh_full;
    logic [SHW-1:0]     sh;
    logic               tiny;
    logic               big;
    logic [SE-1:0]      base;
    logic [WIDE-1:0]    wide;
    logic [KEEP-1:0]    kept;
    logic               guard;
    logic               sticky;
    logic               inexact;
    logic               inc;
    logic [KEEP:0]      rounded;
    logic [SW-2:0]      sum;
    logic               ovf;
    logic               to_max;

    always_comb begin
        sgn    = dbl_i[DW-1];
        ex     = dbl_i[DW-2 -: DE];
        fr     = dbl_i[DF-1:0];
        ex_eff = (ex == '0) ? DE'(1) : ex;
        mant   = {ex != '0, fr};
        es     = $signed({{(EW-DE){1'b0}}, ex_eff}) - EW'(REBIAS);

        tiny    = (es <= 0);
        big     = (es > EW'(EMAXB));
        sh_full = EW'(1) - es;
        if (!tiny)                    sh = '0;
        else if (sh_full > EW'(31))   sh = SHW'(31);
        else                          sh = sh_full[SHW-1:0];
        base = (tiny || big) ? '0 : (es[SE-1:0] - SE'(1));

        wide    = {mant, {PADW{1'b0}}} >> sh;
        kept    = wide[WIDE-1 -: KEEP];
        guard   = wide[WIDE-1-KEEP];
        sticky  = |wide[WIDE-KEEP-2:0];
        inexact = guard | sticky;

        unique case (rm_i)
            RM_RNE:  inc = guard & (sticky | kept[0]);
            RM_RDN:  inc = inexact & sgn;
            RM_RUP:  inc = inexact & ~sgn;
            default: inc = 1'b0;
        endcase

        rounded = {1'b0, kept} + {{KEEP{1'b0}}, inc};
        // hidden bit of a normal result carries into the exponent field
        sum     = {base, {SF{1'b0}}} + {{(SW-2-KEEP){1'b0}}, rounded};
        ovf     = big || (sum[SW-2 -: SE] == {SE{1'b1}});
        to_max  = (rm_i == RM_RTZ) || (rm_i == RM_RDN && !sgn) ||
                  (rm_i == RM_RUP && sgn);

        flg_o     = '0;
        flg_o.den = (ex == '0) && (fr != '0);

        if (ex == {DE{1'b1}} && fr != '0) begin
            sgl_o     = {sgn, {SE{1'b1}}, 1'b1, fr[DF-2 -: NANPW]};
            flg_o.inv = ~fr[DF-1];
        end else if (ex == {DE{1'b1}}) begin
            sgl_o = {sgn, {SE{1'b1}}, {SF{1'b0}}};
        end else if (ex == '0 && fr == '0) begin
            sgl_o = {sgn, {(SW-1){1'b0}}};
        end else if (ovf) begin
            sgl_o     = to_max ? {sgn, SE'(EMAXB), {SF{1'b1}}}
                               : {sgn, {SE{1'b1}}, {SF{1'b0}}};
            flg_o.ovf = 1'b1;
            flg_o.pre = 1'b1;
        end else begin
            sgl_o     = {sgn, sum};
            flg_o.pre = inexact;
            flg_o.unf = tiny & inexact;
        end
    end
endmodule

// File: rtl/cvt_lane_gate.sv
module cvt_lane_gate
    import cvt_pkg::*;
#(
    parameter int LW = 32
) (
    input  logic [LW-1:0] conv_i,
    input  fpflags_t      cflg_i,
    input  logic [LW-1:0] old_i,
    input  logic          mask_en_i,
    input  logic          mask_bit_i,
    input  logic          zero_mode_i,
    output logic [LW-1:0] lane_o,
    output fpflags_t      flg_o
);
    logic write_en;

    always_comb begin
        write_en = ~mask_en_i | mask_bit_i;
        if (write_en) begin
            lane_o = conv_i;
            flg_o  = cflg_i;
        end else begin
            lane_o = zero_mode_i ? '0 : old_i;
            flg_o  = '0;
        end
    end
endmodule

// File: rtl/dp2sp_cvt_unit.sv
module dp2sp_cvt_unit
    import cvt_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             valid_i,
    input  logic [VEC_W-1:0] src1_i,
    input  logic [DW-1:0]    src2_i,
    input  logic [SW-1:0]    old_lo_i,
    input  logic [1:0]       ctl_rm_i,
    input  logic [1:0]       insn_rm_i,
    input  logic             er_en_i,
    input  logic             src_reg_i,
    input  logic             mask_en_i,
    input  logic             mask_bit_i,
    input  logic             zero_mode_i,
    output logic             valid_o,
    output logic [VEC_W-1:0] dest_o,
    output logic             flag_inv_o,
    output logic             flag_den_o,
    output logic             flag_ovf_o,
    output logic             flag_unf_o,
    output logic             flag_pre_o
);
    localparam int UPW = VEC_W - SW;

    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] dst;
        fpflags_t         flg;
    } state_t;

    state_t        st_d, st_q;
    rmode_e        rm_sel;
    logic [SW-1:0] conv_val;
    fpflags_t      conv_flg;
    logic [SW-1:0] lane_val;
    fpflags_t      lane_flg;

    cvt_rm_pick u_rm (
        .ctl_rm_i  (rmode_e'(ctl_rm_i)),
        .insn_rm_i (rmode_e'(insn_rm_i)),
        .src_reg_i (src_reg_i),
        .er_en_i   (er_en_i),
        .rm_o      (rm_sel)
    );

    cvt_d2s_core u_core (
        .dbl_i (src2_i),
        .rm_i  (rm_sel),
        .sgl_o (conv_val),
        .flg_o (conv_flg)
    );

    cvt_lane_gate #(.LW(SW)) u_gate (
        .conv_i      (conv_val),
        .cflg_i      (conv_flg),
        .old_i       (old_lo_i),
        .mask_en_i   (mask_en_i),
        .mask_bit_i  (mask_bit_i),
        .zero_mode_i (zero_mode_i),
        .lane_o      (lane_val),
        .flg_o       (lane_flg)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = valid_i;
        if (valid_i) begin
            st_d.dst = {src1_i[VEC_W-1 -: UPW], lane_val};
            st_d.flg = lane_flg;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign valid_o    = st_q.vld;
    assign dest_o     = st_q.dst;
    assign flag_inv_o = st_q.flg.inv;
    assign flag_den_o = st_q.flg.den;
    assign flag_ovf_o = st_q.flg.ovf;
    assign flag_unf_o = st_q.flg.unf;
    assign flag_pre_o = st_q.flg.pre;
endmodule

// File: rtl/dp2sp_cvt_chk.sv
module dp2sp_cvt_chk #(
    parameter int VEC_W = 128
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             valid_i,
    input logic [VEC_W-1:0] src1_i,
    input logic [31:0]      old_lo_i,
    input logic             mask_en_i,
    input logic             mask_bit_i,
    input logic             zero_mode_i,
    input logic             valid_o,
    input logic [VEC_W-1:0] dest_o,
    input logic             flag_inv_o,
    input logic             flag_den_o,
    input logic             flag_ovf_o,
    input logic             flag_unf_o,
    input logic             flag_pre_o
);
    AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> valid_o); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> (!valid_o && $stable(dest_o))); // R1
    AST_UPPER_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> dest_o[VEC_W-1:32] == $past(src1_i[VEC_W-1:32])); // R2
    AST_OVF_INEXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flag_ovf_o |-> flag_pre_o); // R5
    AST_UNF_INEXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flag_unf_o |-> flag_pre_o); // R6
    AST_NAN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flag_inv_o |-> dest_o[30:22] == 9'h1FF); // R7
    AST_MERGE_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && mask_en_i && !mask_bit_i && !zero_mode_i)
        |=> dest_o[31:0] == $past(old_lo_i)); // R10
    AST_ZERO_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && mask_en_i && !mask_bit_i && zero_mode_i)
        |=> dest_o[31:0] == 32'h0); // R10
    AST_MASK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && mask_en_i && !mask_bit_i)
        |=> !(flag_inv_o || flag_den_o || flag_ovf_o || flag_unf_o || flag_pre_o)); // R11
endmodule

bind dp2sp_cvt_unit dp2sp_cvt_chk #(.VEC_W(VEC_W)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (valid_i),
    .src1_i      (src1_i),
    .old_lo_i    (old_lo_i),
    .mask_en_i   (mask_en_i),
    .mask_bit_i  (mask_bit_i),
    .zero_mode_i (zero_mode_i),
    .valid_o     (valid_o),
    .dest_o      (dest_o),
    .flag_inv_o  (flag_inv_o),
    .flag_den_o  (flag_den_o),
    .flag_ovf_o  (flag_ovf_o),
    .flag_unf_o  (flag_unf_o),
    .flag_pre_o  (flag_pre_o)
);

// File: tb/dp2sp_cvt_unit_tb_top.sv
module dp2sp_cvt_unit_tb_top;
    localparam int PERIOD = 8;

    localparam logic [4:0] F_NONE = 5'b00000;
    localparam logic [4:0] F_I = 5'b10000;
    localparam logic [4:0] F_D = 5'b01000;
    localparam logic [4:0] F_O = 5'b00100;
    localparam logic [4:0] F_U = 5'b00010;
    localparam logic [4:0] F_P = 5'b00001;

    localparam logic [1:0] RNE = 2'b00;
    localparam logic [1:0] RDN = 2'b01;
    localparam logic [1:0] RUP = 2'b10;
    localparam logic [1:0] RTZ = 2'b11;

    typedef struct {
        logic [127:0] dst;
        logic [4:0]   flg;
        string        req;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid_i = 1'b0;
    logic [127:0] src1 = '0;
    logic [63:0]  src2 = '0;
    logic [31:0]  old_lo = '0;
    logic [1:0]   ctl_rm = '0;
    logic [1:0]   insn_rm = '0;
    logic         er_en = 1'b0;
    logic         src_reg = 1'b0;
    logic         mask_en = 1'b0;
    logic         mask_bit = 1'b0;
    logic         zero_mode = 1'b0;
    logic         valid_o;
    logic [127:0] dest_o;
    logic         f_inv, f_den, f_ovf, f_unf, f_pre;

    int   checks = 0;
    int   errors = 0;
    int   seq = 0;
    bit   done = 0;
    exp_t sb[$];

    always #(PERIOD/2) clk = ~clk;

    dp2sp_cvt_unit dut_i (
        .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
        .src1_i(src1), .src2_i(src2), .old_lo_i(old_lo),
        .ctl_rm_i(ctl_rm), .insn_rm_i(insn_rm), .er_en_i(er_en),
        .src_reg_i(src_reg), .mask_en_i(mask_en), .mask_bit_i(mask_bit),
        .zero_mode_i(zero_mode), .valid_o(valid_o), .dest_o(dest_o),
        .flag_inv_o(f_inv), .flag_den_o(f_den), .flag_ovf_o(f_ovf),
        .flag_unf_o(f_unf), .flag_pre_o(f_pre)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // driver: one request per call, expected item pushed to the scoreboard
    task automatic go(input logic [63:0] d, input logic [1:0] crm,
                      input logic [1:0] irm, input bit reg_src, input bit er,
                      input bit men, input bit mbit, input bit zmode,
                      input logic [31:0] old, input logic [31:0] exp_lo,
                      input logic [4:0] exp_f, input string req);
        exp_t e;
        @(negedge clk);
        seq++;
        src1      = {32'hC0DE0000 + seq, 32'h12340000 ^ seq,
                     32'hFACE0000 + seq, 32'hDEAD0000 + seq};
        src2      = d;
        ctl_rm    = crm;
        insn_rm   = irm;
        src_reg   = reg_src;
        er_en     = er;
        mask_en   = men;
        mask_bit  = mbit;
        zero_mode = zmode;
        old_lo    = old;
        valid_i   = 1'b1;
        e.dst = {src1[127:32], exp_lo};   // R2 upper lanes from src1
        e.flg = exp_f;
        e.req = req;
        sb.push_back(e);
    endtask

    task automatic cv(input logic [63:0] d, input logic [1:0] rm,
                      input logic [31:0] exp_lo, input logic [4:0] exp_f,
                      input string req);
        go(d, rm, RTZ, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, exp_lo, exp_f, req);
    endtask

    // monitor: result due one edge after its request (R1)
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (sb.size() == 0) begin
                check(1'b0, "R1", "unexpected valid_o", 128'h1, 128'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(dest_o == e.dst, e.req, "dest", dest_o, e.dst);
                check({f_inv, f_den, f_ovf, f_unf, f_pre} == e.flg, e.req,
                      "flags", 128'({f_inv, f_den, f_ovf, f_unf, f_pre}),
                      128'(e.flg));
            end
        end
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] held;
        repeat (3) @(negedge clk);
        // R12 reset state
        check(valid_o == 1'b0, "R12", "valid_o in reset", 128'(valid_o), 128'h0);
        check(dest_o == '0, "R12", "dest_o in reset", dest_o, 128'h0);
        check({f_inv, f_den, f_ovf, f_unf, f_pre} == 5'b0, "R12",
              "flags in reset", 128'({f_inv, f_den, f_ovf, f_unf, f_pre}), 128'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // plain values
        cv(64'h3FF0000000000000, RNE, 32'h3F800000, F_NONE, "R4 one");
        cv(64'hC004000000000000, RNE, 32'hC0200000, F_NONE, "R4 minus2.5");
        // R4 ties and directions
        cv(64'h3FF0000010000000, RNE, 32'h3F800000, F_P, "R4 tie even down");
        cv(64'h3FF0000030000000, RNE, 32'h3F800002, F_P, "R4 tie odd up");
        cv(64'h3FF0000018000000, RNE, 32'h3F800001, F_P, "R4 above half");
        cv(64'h3FF0000010000000, RUP, 32'h3F800001, F_P, "R4 up positive");
        cv(64'h3FF0000010000000, RDN, 32'h3F800000, F_P, "R4 down positive");
        cv(64'h3FF0000018000000, RTZ, 32'h3F800000, F_P, "R4 toward zero");
        cv(64'hBFF0000010000000, RDN, 32'hBF800001, F_P, "R4 down negative");
        cv(64'hBFF0000010000000, RUP, 32'hBF800000, F_P, "R4 up negative");
        // R5 overflow
        cv(64'h7E00000000000000, RNE, 32'h7F800000, F_O | F_P, "R5 inf");
        cv(64'h7E00000000000000, RTZ, 32'h7F7FFFFF, F_O | F_P, "R5 max rtz");
        cv(64'hFE00000000000000, RUP, 32'hFF7FFFFF, F_O | F_P, "R5 neg max");
        cv(64'hFE00000000000000, RDN, 32'hFF800000, F_O | F_P, "R5 neg inf");
        cv(64'h47EFFFFFF0000000, RNE, 32'h7F800000, F_O | F_P, "R5 round carry");
        cv(64'h47EFFFFFF0000000, RTZ, 32'h7F7FFFFF, F_P, "R5 no carry");
        // R6 tiny results
        cv(64'h37D0000000000000, RNE, 32'h00080000, F_NONE, "R6 exact denorm");
        cv(64'h380FFFFFF0000000, RNE, 32'h00800000, F_U | F_P, "R6 round to normal");
        // R7 NaNs
        cv(64'h7FF8000000000001, RNE, 32'h7FC00000, F_NONE, "R7 quiet");
        cv(64'h7FF4000000000000, RNE, 32'h7FE00000, F_I, "R7 signalling");
        cv(64'hFFF0000000000001, RNE, 32'hFFC00000, F_I, "R7 neg signalling");
        // R8 specials
        cv(64'h7FF0000000000000, RUP, 32'h7F800000, F_NONE, "R8 inf");
        cv(64'hFFF0000000000000, RNE, 32'hFF800000, F_NONE, "R8 neg inf");
        cv(64'h8000000000000000, RNE, 32'h80000000, F_NONE, "R8 neg zero");
        // R9 double denormal
        cv(64'h0000000000000001, RNE, 32'h00000000, F_D | F_U | F_P, "R9 denorm rne");
        cv(64'h0000000000000001, RUP, 32'h00000001, F_D | F_U | F_P, "R9 denorm rup");
        // R3 rounding source
        go(64'h3FF0000010000000, RNE, RUP, 1'b1, 1'b1, 0, 0, 0, 32'h0,
           32'h3F800001, F_P, "R3 override used");
        go(64'h3FF0000010000000, RNE, RUP, 1'b0, 1'b1, 0, 0, 0, 32'h0,
           32'h3F800000, F_P, "R3 memory operand");
        go(64'h3FF0000010000000, RUP, RNE, 1'b1, 1'b0, 0, 0, 0, 32'h0,
           32'h3F800001, F_P, "R3 enable off");
        // R10 / R11 masking
        go(64'h7FF4000000000000, RNE, RNE, 0, 0, 1'b1, 1'b0, 1'b0, 32'h13579BDF,
           32'h13579BDF, F_NONE, "R10 R11 merge");
        go(64'h7FF4000000000000, RNE, RNE, 0, 0, 1'b1, 1'b0, 1'b1, 32'h13579BDF,
           32'h00000000, F_NONE, "R10 R11 zeroing");
        go(64'hC004000000000000, RNE, RNE, 0, 0, 1'b1, 1'b1, 1'b1, 32'h13579BDF,
           32'hC0200000, F_NONE, "R10 mask set");

        // R1 hold while idle
        @(negedge clk);
        valid_i = 1'b0;
        @(negedge clk);
        held = dest_o;
        src1 = ~src1;
        src2 = 64'h3FF0000000000000;
        old_lo = 32'hFFFFFFFF;
        repeat (3) @(negedge clk);
        check(dest_o == held, "R1", "hold while idle", dest_o, held);
        check(valid_o == 1'b0, "R1", "valid low while idle", 128'(valid_o), 128'h0);
        check(sb.size() == 0, "R1", "results outstanding", 128'(sb.size()), 128'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule